// File: doc/BRIEF.md
# Zero-Wait APB Word Memory Completer

This block is an APB completer that fronts a 4 KB memory of 1024 32-bit words. A requester starts a transfer with a setup cycle and finishes it in the access cycle that follows. The block never stalls, so every transfer takes exactly two bus cycles and there is no back-pressure path. Writes land in the array on the rising edge that closes the access cycle. Read data is presented for the whole access cycle. Outside a read the data output sits at zero.

Each word carries a written flag. A word whose flag is clear reads as zero, whatever its storage cell holds. The active-low reset acts asynchronously: it zeroes the read data and clears every flag at once. The storage array itself is never reset.

Only address bits [11:2] pick a word. The upper address bits and the two byte-offset bits are ignored. A setup cycle that is not followed by an enabled access cycle is dropped.

Top module: `apbmem_slave`

## Requirements
- R1: A transfer begins only when a rising edge samples bus_sel=1 with bus_en=0. bus_wr in that cycle picks write (1) or read (0). A cycle with bus_sel=1 and bus_en=1 that does not follow such a setup cycle stores nothing.
- R2: For a write, bus_wdata sampled at the edge that ends the access cycle (bus_sel=1, bus_en=1) is stored at word bus_addr[11:2].
- R3: For a read, bus_rdata carries the stored word at bus_addr[11:2] from the edge that samples the setup cycle until the edge that ends the access cycle.
- R4: A read of a word never written since the last reset returns zero.
- R5: While rst_n is low, bus_rdata is zero at once, without waiting for a clock edge. After reset every word reads as zero.
- R6: bus_addr bits [31:12] and [1:0] have no effect on which word is written or read.
- R7: A read setup cycle that immediately follows a write access cycle to the same word returns the newly written value.
- R8: bus_rdata is zero in every cycle that does not follow a sampled read setup cycle.
- R9: A setup cycle followed by an edge without bus_sel=1 and bus_en=1 is cancelled. For a write, the target word keeps its previous contents and its written flag.
- R10: Writes issued back to back, with no idle cycle between them, are all stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Completer selected |
| bus_en | input | 1 | High in the access cycle |
| bus_addr | input | 32 | Byte address; bits [11:2] select the word |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero outside reads |

## Verification
The assertions assume that a requester holds address, direction and write data steady from the setup cycle through the access cycle. They also assume the requester keeps the bus idle while reset is held. The bench's bus tasks keep to these rules. The only exceptions are the deliberate cancelled setups and a stray enabled cycle with no setup, which the block must tolerate. Every cycle is compared with a behavioural model kept in an associative array, so an unwritten word and a word cleared by reset are both checked as zero.

// File: rtl/apbmem_pkg.sv
package apbmem_pkg;

  // Tracked bus phase: which kind of setup the previous edge sampled.
  typedef enum logic [1:0] {
    PH_IDLE     = 2'd0,
    PH_SETUP_WR = 2'd1,
    PH_SETUP_RD = 2'd2
  } apbmem_phase_e;

  function automatic apbmem_phase_e next_phase(input logic sel, input logic en,
                                               input logic wr);
    if (sel && !en) return wr ? PH_SETUP_WR : PH_SETUP_RD;
    return PH_IDLE;
  endfunction

endpackage

// File: rtl/apbmem_phase.sv
module apbmem_phase
  import apbmem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic en,
  input  logic wr,
  output logic rd_launch,
  output logic wr_commit
);

  apbmem_phase_e phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= next_phase(sel, en, wr);
  end

  // A read is launched on the setup edge itself.
  assign rd_launch = sel && !en && !wr;
  // A write commits only on an enabled cycle that follows a write setup.
  assign wr_commit = (phase_q == PH_SETUP_WR) && sel && en;

endmodule

// File: rtl/apbmem_store.sv
module apbmem_store #(
  parameter int DATA_W     = 32,
  parameter int DEPTH_LOG2 = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [DEPTH_LOG2-1:0] widx,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [DEPTH_LOG2-1:0] ridx,
  output logic [DATA_W-1:0]     rword,
  output logic [(1<<DEPTH_LOG2)-1:0] valid_vec
);

  localparam int DEPTH = 1 << DEPTH_LOG2;

  logic [DATA_W-1:0] cells_q [DEPTH];

  // The storage cells carry no reset; validity lives in the flag vector.
  always_ff @(posedge clk) begin
    if (we) cells_q[widx] <= wdata;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  valid_vec[g] <= 1'b0;
      else if (we && (widx == DEPTH_LOG2'(g)))     valid_vec[g] <= 1'b1;
    end
  end

  assign rword = valid_vec[ridx] ? cells_q[ridx] : '0;

endmodule

// File: rtl/apbmem_rdata.sv
module apbmem_rdata #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (launch) rdata <= word;
    else             rdata <= '0;
  end

endmodule

// File: rtl/apbmem_slave.sv
module apbmem_slave #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int DEPTH_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int IDX_LO = $clog2(DATA_W / 8);
  localparam int IDX_HI = IDX_LO + DEPTH_LOG2;
  localparam int DEPTH  = 1 << DEPTH_LOG2;

  logic [DEPTH_LOG2-1:0] word_idx;
  logic                  rd_launch;
  logic                  mem_we;
  logic [DATA_W-1:0]     lookup;
  logic [DEPTH-1:0]      valid_vec;
  logic                  unused_addr_bits;

  assign word_idx         = bus_addr[IDX_LO +: DEPTH_LOG2];
  assign unused_addr_bits = ^{bus_addr[ADDR_W-1:IDX_HI], bus_addr[IDX_LO-1:0]};

  apbmem_phase u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (bus_sel),
    .en        (bus_en),
    .wr        (bus_wr),
    .rd_launch (rd_launch),
    .wr_commit (mem_we)
  );

  apbmem_store #(.DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (mem_we),
    .widx      (word_idx),
    .wdata     (bus_wdata),
    .ridx      (word_idx),
    .rword     (lookup),
    .valid_vec (valid_vec)
  );

  apbmem_rdata #(.DATA_W(DATA_W)) u_rdata (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (rd_launch),
    .word   (lookup),
    .rdata  (bus_rdata)
  );

endmodule

// File: rtl/apbmem_slave_chk.sv
module apbmem_slave_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int DEPTH_LOG2 = 10
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         bus_sel,
  input logic                         bus_en,
  input logic [ADDR_W-1:0]            bus_addr,
  input logic                         bus_wr,
  input logic [DATA_W-1:0]            bus_rdata,
  input logic                         mem_we,
  input logic [(1<<DEPTH_LOG2)-1:0]   valid_vec
);

  localparam int IDX_LO = $clog2(DATA_W / 8);

  logic [DEPTH_LOG2-1:0] chk_idx;
  assign chk_idx = bus_addr[IDX_LO +: DEPTH_LOG2];

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEARS: assert (bus_rdata == '0 && valid_vec == '0); // R5
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !(bus_sel && !bus_en && !bus_wr) |=> bus_rdata == '0); // R8
  AST_WRITE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> ($past(bus_sel && !bus_en && bus_wr) && bus_sel && bus_en)); // R2
  AST_CANCEL_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n) ($past(bus_sel && !bus_en) && !(bus_sel && bus_en)) |-> !mem_we); // R9
  AST_FLAGS_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !mem_we |=> $stable(valid_vec)); // R1
  AST_UNWRITTEN_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (bus_sel && !bus_en && !bus_wr && !valid_vec[chk_idx]) |=> bus_rdata == '0); // R4

endmodule

bind apbmem_slave apbmem_slave_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_en    (bus_en),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rdata (bus_rdata),
  .mem_we    (mem_we),
  .valid_vec (valid_vec)
);

// File: tb/apbmem_slave_tb.sv
`timescale 1ns/1ps
module apbmem_slave_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_en = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  string cur_req = "R8";

  always #10 clk = ~clk;

  apbmem_slave dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_en(bus_en),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: word map, pending write flag, expected output.
  logic [31:0] ref_mem [int];
  logic [31:0] exp_rdata = '0;
  bit          ref_wr_pending = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_mem.delete();
      exp_rdata = '0;
      ref_wr_pending = 1'b0;
    end else begin
      int key;
      key = int'(bus_addr[11:2]);
      if (bus_sel && !bus_en && !bus_wr)
        exp_rdata = ref_mem.exists(key) ? ref_mem[key] : 32'h0;
      else
        exp_rdata = 32'h0;
      if (ref_wr_pending && bus_sel && bus_en) ref_mem[key] = bus_wdata;
      ref_wr_pending = bus_sel && !bus_en && bus_wr;
    end
  end

  always @(negedge clk) check(cur_req, bus_rdata, exp_rdata);

  task automatic bus_write(logic [31:0] a, logic [31:0] d, bit cancel = 1'b0);
    @(negedge clk);
    bus_sel = 1'b1; bus_en = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    if (cancel) begin bus_sel = 1'b0; bus_en = 1'b0; end
    else        bus_en = 1'b1;
  endtask

  task automatic bus_read(logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_en = 1'b0; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_en = 1'b1;
  endtask

  task automatic bus_idle();
    @(negedge clk);
    bus_sel = 1'b0; bus_en = 1'b0; bus_wdata = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    check("R5", bus_rdata, 32'h0);
    rst_n = 1'b1;
    bus_idle();

    cur_req = "R4";
    bus_read(32'h0000_0040, rd);
    check("R4", rd, 32'h0);

    cur_req = "R10";
    for (int i = 0; i < 8; i++) bus_write(32'(i * 4), 32'hA500_0000 + 32'(i));
    bus_idle();
    cur_req = "R3";
    for (int i = 0; i < 8; i++) begin
      bus_read(32'(i * 4), rd);
      check("R3", rd, 32'hA500_0000 + 32'(i));
    end
    bus_idle();

    cur_req = "R7";
    bus_write(32'h0000_0300, 32'hC0DE_0007);
    bus_read(32'h0000_0300, rd);
    check("R7", rd, 32'hC0DE_0007);
    bus_write(32'h0000_0300, 32'h1234_5678);
    bus_read(32'h0000_0300, rd);
    check("R7", rd, 32'h1234_5678);
    bus_idle();

    cur_req = "R6";
    bus_write(32'hABCD_E00A, 32'h0066_0066);
    bus_idle();
    bus_read(32'h0000_0008, rd);
    check("R6", rd, 32'h0066_0066);
    bus_read(32'hFFFF_F00B, rd);
    check("R6", rd, 32'h0066_0066);
    bus_idle();

    cur_req = "R9";
    bus_write(32'h0000_0100, 32'hDEAD_0009, 1'b1);
    bus_read(32'h0000_0100, rd);
    check("R9", rd, 32'h0);
    bus_write(32'h0000_0004, 32'hDEAD_0004, 1'b1);
    bus_read(32'h0000_0004, rd);
    check("R9", rd, 32'hA500_0001);
    bus_idle();

    cur_req = "R1";
    @(negedge clk);
    bus_sel = 1'b1; bus_en = 1'b1; bus_wr = 1'b1;
    bus_addr = 32'h0000_0200; bus_wdata = 32'hBAD0_0001;
    bus_idle();
    bus_read(32'h0000_0200, rd);
    check("R1", rd, 32'h0);
    bus_idle();

    cur_req = "R8";
    @(negedge clk);
    bus_sel = 1'b0; bus_en = 1'b1; bus_wr = 1'b0; bus_addr = 32'h0;
    @(negedge clk);
    check("R8", bus_rdata, 32'h0);
    bus_idle();

    cur_req = "R5";
    @(negedge clk);
    bus_sel = 1'b1; bus_en = 1'b0; bus_wr = 1'b0; bus_addr = 32'h0000_0300;
    @(negedge clk);
    check("R5", bus_rdata, 32'h1234_5678);
    bus_sel = 1'b0;
    #2 rst_n = 1'b0;
    #1 check("R5", bus_rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    bus_idle();
    bus_read(32'h0000_0300, rd);
    check("R5", rd, 32'h0);
    bus_read(32'h0000_0000, rd);
    check("R5", rd, 32'h0);
    bus_idle();
    repeat (2) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule